// File: doc/BRIEF.md
# Multi-Port Receive Burst Scheduler

This block drains four per-port receive FIFOs onto one shared 32-bit receive bus. It visits the ports in a fixed circular order. A port is skipped if it is disabled or has nothing queued. The selected port gets one burst. Every burst opens with an in-band address cycle that carries the port number. Data words follow, and a programmable number of idle clocks separates one burst from the next address cycle.

A burst ends when the configured quantum of 64, 128 or 256 bytes has been sent, or at the end of a packet, whichever comes first. The scheduler then moves to the next port in order. A packet cut off by the quantum picks up where it stopped on that port's next turn, behind a fresh address cycle. The FIFOs are first-word-fall-through. The block pops exactly one word for every data word it drives.

Top module: `spi3_rx_sched`

## Requirements
- R1: While rst_ni is low, rdat_o, rval_o, rsx_o, reop_o, rmod_o and fifo_pop_o are all zero.
- R2: Ports are considered in the order 0, 1, 2, 3, 0, starting after reset at port 0 and after each burst at the port following the one just served. A port that is disabled or whose FIFO is empty is passed over.
- R3: Each burst begins with one address cycle: rsx_o=1, rval_o=0, rdat_o[1:0] holds the port number and rdat_o[31:2] is zero. The cycle that follows is not an address cycle.
- R4: Data cycles have rval_o=1 and rsx_o=0 and carry the selected port's FIFO words in FIFO order. Each data cycle pops exactly one word, and only from a non-empty FIFO.
- R5: burst_sel_i picks the burst quantum: 00 gives 16 words (64 bytes), 01 gives 32 words (128 bytes), 10 or 11 gives 64 words (256 bytes).
- R6: A burst stops after the word that carries end-of-packet, even if the quantum is not used up.
- R7: reop_o is high only on the word flagged end-of-packet, and rmod_o then copies that word's valid-byte code (00 = 4 bytes, 01 = 3, 10 = 2, 11 = 1). On every other data word rmod_o is 00, whatever the FIFO presents.
- R8: Between the last data word of a burst and the next address cycle there are exactly pause_i idle cycles (0 to 15), with rval_o and rsx_o both low.
- R9: When no port is eligible, the bus stays idle and eligibility is re-checked every clock. A port that becomes eligible later is then served.
- R10: A packet longer than the quantum continues on the same port's next turn, after a new address cycle, with no word lost or repeated.
- R11: A disabled port is never popped, even if its FIFO holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_data_i | input | 128 | Head word of each port FIFO, port p at bits [32p+31:32p] |
| fifo_eop_i | input | 4 | Head word closes its packet, one bit per port |
| fifo_mod_i | input | 8 | Valid-byte code of the head word, 2 bits per port |
| fifo_empty_i | input | 4 | FIFO has no word, one bit per port |
| fifo_pop_o | output | 4 | Consume the head word, one bit per port |
| port_en_i | input | 4 | Port may be scheduled |
| burst_sel_i | input | 2 | Burst quantum select |
| pause_i | input | 4 | Idle clocks between bursts |
| rdat_o | output | 32 | Bus data or port address |
| rval_o | output | 1 | Data cycle |
| rsx_o | output | 1 | Address cycle |
| reop_o | output | 1 | Last word of a packet |
| rmod_o | output | 2 | Valid-byte code of the last word |

## Verification
The bench aims at a packet that outlives the 16-word quantum. A scheduler that ignored the quantum would keep one port on the bus, and one that lost its place would drop or repeat words on resume. It mixes empty and disabled ports among busy ones to catch a rotation that serves the wrong port, pops a disabled FIFO, or restarts from port 0 every time. Single-word packets, pause values of 0, 1, 7 and 15, and junk valid-byte codes on non-final words expose off-by-one gaps and rmod_o leaking through. A run that starts with every FIFO empty shows whether the scheduler stalls for good or picks up a port that fills later.

// File: rtl/spi3_rx_pkg.sv
package spi3_rx_pkg;
  typedef enum logic [1:0] {ST_SCAN, ST_DATA, ST_PAUSE} sched_st_e;

  localparam int BCNT_W = 7;

  // burst quantum in 32-bit words
  function automatic logic [BCNT_W-1:0] burst_words(input logic [1:0] sel);
    case (sel)
      2'b00:   return BCNT_W'(16);
      2'b01:   return BCNT_W'(32);
      default: return BCNT_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/spi3_rr_pick.sv
module spi3_rr_pick #(
  parameter int NPORT = 4,
  parameter int PW    = $clog2(NPORT)
) (
  input  logic [NPORT-1:0] req_i,
  input  logic [PW-1:0]    start_i,
  output logic             vld_o,
  output logic [PW-1:0]    idx_o
);
  // farthest first so the nearest requester from start_i wins
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int k = NPORT - 1; k >= 0; k--) begin
      automatic int j = (int'(start_i) + k) % NPORT;
      if (req_i[j]) begin
        vld_o = 1'b1;
        idx_o = PW'(j);
      end
    end
  end
endmodule

// File: rtl/spi3_word_ctr.sv
module spi3_word_ctr #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = (cnt_q == limit_i - CW'(1));
endmodule

// File: rtl/spi3_gap_timer.sv
module spi3_gap_timer #(
  parameter int GW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [GW-1:0] val_i,
  input  logic          dec_i,
  output logic          expire_o
);
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - GW'(1);
  end

  assign expire_o = (cnt_q == GW'(1));
endmodule

// File: rtl/spi3_rx_sched.sv
module spi3_rx_sched
  import spi3_rx_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int DW    = 32,
  parameter int GW    = 4,
  parameter int PW    = $clog2(NPORT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NPORT*DW-1:0] fifo_data_i,
  input  logic [NPORT-1:0]   fifo_eop_i,
  input  logic [NPORT*2-1:0] fifo_mod_i,
  input  logic [NPORT-1:0]   fifo_empty_i,
  output logic [NPORT-1:0]   fifo_pop_o,
  input  logic [NPORT-1:0]   port_en_i,
  input  logic [1:0]         burst_sel_i,
  input  logic [GW-1:0]      pause_i,
  output logic [DW-1:0]      rdat_o,
  output logic               rval_o,
  output logic               rsx_o,
  output logic               reop_o,
  output logic [1:0]         rmod_o
);
  sched_st_e      st_q;
  logic [PW-1:0]  rr_q, cur_q, rr_nxt, pick_idx;
  logic           pick_vld;
  logic [NPORT-1:0] elig;
  logic           cur_vld, cur_eop, take, last_word, burst_end, gap_expire;
  logic [DW-1:0]  cur_word;
  logic [1:0]     cur_mod;

  assign elig     = port_en_i & ~fifo_empty_i;
  assign cur_vld  = !fifo_empty_i[cur_q];
  assign cur_eop  = fifo_eop_i[cur_q];
  assign cur_word = fifo_data_i[int'(cur_q)*DW +: DW];
  assign cur_mod  = fifo_mod_i[int'(cur_q)*2 +: 2];
  assign take     = (st_q == ST_DATA) && cur_vld;
  assign burst_end = take && (cur_eop || last_word);
  assign rr_nxt   = (cur_q == PW'(NPORT - 1)) ? '0 : cur_q + PW'(1);

  for (genvar p = 0; p < NPORT; p++) begin : g_pop
    assign fifo_pop_o[p] = take && (cur_q == PW'(p));
  end

  spi3_rr_pick #(.NPORT(NPORT), .PW(PW)) u_pick (
    .req_i   (elig),
    .start_i (rr_q),
    .vld_o   (pick_vld),
    .idx_o   (pick_idx)
  );

  spi3_word_ctr #(.CW(BCNT_W)) u_wctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q == ST_SCAN),
    .inc_i   (take),
    .limit_i (burst_words(burst_sel_i)),
    .last_o  (last_word)
  );

  spi3_gap_timer #(.GW(GW)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (burst_end),
    .val_i    (pause_i),
    .dec_i    (st_q == ST_PAUSE),
    .expire_o (gap_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SCAN;
      rr_q   <= '0;
      cur_q  <= '0;
      rdat_o <= '0;
      rval_o <= 1'b0;
      rsx_o  <= 1'b0;
      reop_o <= 1'b0;
      rmod_o <= 2'b00;
    end else begin
      rdat_o <= '0;
      rval_o <= 1'b0;
      rsx_o  <= 1'b0;
      reop_o <= 1'b0;
      rmod_o <= 2'b00;
      unique case (st_q)
        ST_SCAN: if (pick_vld) begin
          rsx_o  <= 1'b1;
          rdat_o <= DW'(pick_idx);
          cur_q  <= pick_idx;
          st_q   <= ST_DATA;
        end
        ST_DATA: if (take) begin
          rval_o <= 1'b1;
          rdat_o <= cur_word;
          reop_o <= cur_eop;
          rmod_o <= cur_eop ? cur_mod : 2'b00;
          if (burst_end) begin
            rr_q <= rr_nxt;
            st_q <= (pause_i != '0) ? ST_PAUSE : ST_SCAN;
          end
        end
        ST_PAUSE: if (gap_expire) st_q <= ST_SCAN;
        default:  st_q <= ST_SCAN;
      endcase
    end
  end
endmodule

// File: rtl/spi3_rx_sched_chk.sv
module spi3_rx_sched_chk #(
  parameter int NPORT = 4,
  parameter int DW    = 32,
  parameter int PW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPORT-1:0] fifo_pop_o,
  input logic [NPORT-1:0] fifo_empty_i,
  input logic [DW-1:0]    rdat_o,
  input logic             rval_o,
  input logic             rsx_o,
  input logic             reop_o,
  input logic [1:0]       rmod_o
);
  p_addr_fmt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsx_o |-> (rdat_o[DW-1:PW] == '0));

  p_addr_then_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsx_o |=> !rsx_o);

  p_bus_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsx_o && rval_o));

  p_pop_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fifo_pop_o));

  p_pop_nonempty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_pop_o & fifo_empty_i) == '0);

  p_eop_is_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reop_o |-> rval_o);

  p_mod_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rval_o && !reop_o) |-> (rmod_o == 2'b00));
endmodule

bind spi3_rx_sched spi3_rx_sched_chk #(.NPORT(NPORT), .DW(DW), .PW(PW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_pop_o   (fifo_pop_o),
  .fifo_empty_i (fifo_empty_i),
  .rdat_o       (rdat_o),
  .rval_o       (rval_o),
  .rsx_o        (rsx_o),
  .reop_o       (reop_o),
  .rmod_o       (rmod_o)
);

// File: tb/tb_spi3_rx_sched.sv
`timescale 1ns/1ps
module tb_spi3_rx_sched;
  localparam int NP = 4, DW = 32, GW = 4, DEPTH = 256, LOGN = 2048;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n;
  logic [NP*DW-1:0]  f_data;
  logic [NP-1:0]     f_eop, f_empty, f_pop, en;
  logic [NP*2-1:0]   f_mod;
  logic [1:0]        bsel;
  logic [GW-1:0]     pause;
  logic [DW-1:0]     rdat;
  logic              rval, rsx, reop;
  logic [1:0]        rmod;

  spi3_rx_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_data_i(f_data), .fifo_eop_i(f_eop),
    .fifo_mod_i(f_mod), .fifo_empty_i(f_empty), .fifo_pop_o(f_pop),
    .port_en_i(en), .burst_sel_i(bsel), .pause_i(pause), .rdat_o(rdat),
    .rval_o(rval), .rsx_o(rsx), .reop_o(reop), .rmod_o(rmod)
  );

  // bench FIFO model
  logic [DW-1:0] m_dat [NP][DEPTH];
  logic          m_eop [NP][DEPTH];
  logic [1:0]    m_mod [NP][DEPTH];
  int            len [NP];
  int            rd  [NP];
  logic          clr_fifo;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      f_empty[p]          = rd[p] >= len[p];
      f_data[p*DW +: DW]  = m_dat[p][rd[p] % DEPTH];
      f_eop[p]            = m_eop[p][rd[p] % DEPTH];
      f_mod[p*2 +: 2]     = m_mod[p][rd[p] % DEPTH];
    end
  end

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (clr_fifo)      rd[p] <= 0;
      else if (f_pop[p]) rd[p] <= rd[p] + 1;
    end
  end

  // bus monitor
  int            n_log = 0, idle_run = 0;
  int            lk [LOGN];
  logic [DW-1:0] ld [LOGN];
  logic          le [LOGN];
  logic [1:0]    lm [LOGN];
  int            lg [LOGN];

  always @(negedge clk) begin
    if (rst_n && n_log < LOGN) begin
      if (rsx) begin
        lk[n_log] = 1; ld[n_log] = rdat; lg[n_log] = idle_run;
        n_log++; idle_run = 0;
      end else if (rval) begin
        lk[n_log] = 2; ld[n_log] = rdat; le[n_log] = reop; lm[n_log] = rmod;
        n_log++; idle_run = 0;
      end else idle_run++;
    end
  end

  int n_chk = 0, n_fail = 0, wd_fail = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      wd_fail = 1;
      $display("FAIL watchdog act=%0d exp=<%0d cycles", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {bsel[57:56], pause[55:52], en[51:48], port3..port0 {npk[11:10], len[9:2], mod[1:0]}}
  localparam logic [57:0] VEC [5] = '{
    {2'd0, 4'd0,  4'hF, {2'd2,8'd3,2'd3},  {2'd0,8'd0,2'd0},  {2'd1,8'd20,2'd0}, {2'd1,8'd4,2'd1}},
    {2'd1, 4'd3,  4'hB, {2'd1,8'd33,2'd1}, {2'd1,8'd8,2'd0},  {2'd1,8'd5,2'd1},  {2'd2,8'd40,2'd2}},
    {2'd2, 4'd15, 4'hF, {2'd0,8'd0,2'd0},  {2'd2,8'd64,2'd0}, {2'd0,8'd0,2'd0},  {2'd1,8'd70,2'd3}},
    {2'd3, 4'd1,  4'h4, {2'd1,8'd6,2'd0},  {2'd1,8'd1,2'd2},  {2'd1,8'd3,2'd1},  {2'd1,8'd2,2'd0}},
    {2'd0, 4'd7,  4'hF, {2'd2,8'd1,2'd3},  {2'd2,8'd1,2'd2},  {2'd2,8'd1,2'd1},  {2'd2,8'd1,2'd0}}
  };

  task automatic push_pkt(input int p, input int pk, input int plen, input logic [1:0] pm);
    for (int w = 0; w < plen; w++) begin
      automatic int i = len[p];
      m_dat[p][i] = {8'(p), 8'(pk), 16'(w)} ^ 32'h5A00_0000;
      m_eop[p][i] = (w == plen - 1);
      m_mod[p][i] = (w == plen - 1) ? pm : (2'(w) | 2'b01);  // junk code on non-final words
      len[p] = i + 1;
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    clr_fifo = 1'b1;
    repeat (2) @(negedge clk);
    clr_fifo = 1'b0;
    for (int p = 0; p < NP; p++) len[p] = 0;
  endtask

  function automatic bit all_done();
    for (int p = 0; p < NP; p++)
      if (en[p] && rd[p] < len[p]) return 1'b0;
    return 1'b1;
  endfunction

  // reference schedule built from requirements R2 R3 R5 R6 R7 R8 R10
  task automatic check_run(input int base);
    automatic int r[NP];
    automatic int ptr = 0, ei = base, bw, first = 1;
    bw = (bsel == 2'b00) ? 16 : (bsel == 2'b01) ? 32 : 64;
    for (int p = 0; p < NP; p++) r[p] = 0;
    for (int guard = 0; guard < 1000; guard++) begin
      automatic int s = -1;
      automatic int cnt = 0;
      automatic bit fin = 1'b0;
      for (int k = 0; k < NP; k++) begin
        automatic int p = (ptr + k) % NP;
        if (s < 0 && en[p] && r[p] < len[p]) s = p;
      end
      if (s < 0) break;
      // address cycle: R2 order, R3 format
      chk(ei < n_log && lk[ei] == 1 && ld[ei] == 32'(s), "R2 R3 address", ld[ei], 32'(s));
      if (!first) chk(ei < n_log && lg[ei] == int'(pause), "R8 gap", 32'(lg[ei]), 32'(pause));
      first = 0;
      ei++;
      while (!fin) begin
        automatic logic [1:0] em = m_eop[s][r[s]] ? m_mod[s][r[s]] : 2'b00;
        chk(ei < n_log && lk[ei] == 2 && ld[ei] == m_dat[s][r[s]],
            "R4 R5 R6 R10 data", ld[ei], m_dat[s][r[s]]);
        chk(ei < n_log && le[ei] == m_eop[s][r[s]] && lm[ei] == em,
            "R7 eop/mod", {29'd0, le[ei], lm[ei]}, {29'd0, m_eop[s][r[s]], em});
        fin = m_eop[s][r[s]] || (cnt + 1 == bw);
        r[s]++; cnt++; ei++;
      end
      ptr = (s + 1) % NP;
    end
    chk(ei == n_log, "R4 event count", 32'(n_log - base), 32'(ei - base));
  endtask

  initial begin
    en = '0; bsel = '0; pause = '0;
    hold_reset();
    // R1: quiet outputs in reset
    repeat (2) @(negedge clk);
    chk(rdat == '0 && !rval && !rsx && !reop && rmod == '0 && f_pop == '0,
        "R1 reset", {rdat[27:0], rval, rsx, reop, |f_pop}, 32'd0);

    foreach (VEC[v]) begin
      automatic int base;
      hold_reset();
      bsel  = VEC[v][57:56];
      pause = VEC[v][55:52];
      en    = VEC[v][51:48];
      for (int p = 0; p < NP; p++) begin
        automatic logic [11:0] f = VEC[v][p*12 +: 12];
        for (int pk = 0; pk < int'(f[11:10]); pk++) push_pkt(p, pk, int'(f[9:2]), f[1:0]);
      end
      base = n_log;
      @(negedge clk);
      rst_n = 1'b1;
      while (!all_done()) @(negedge clk);
      repeat (40) @(negedge clk);
      check_run(base);
      // R11: disabled port with data untouched
      for (int p = 0; p < NP; p++)
        if (!en[p] && len[p] > 0) chk(rd[p] == 0, "R11 disabled pop", 32'(rd[p]), 32'd0);
    end

    // R9: nothing eligible, then one port fills later
    begin
      automatic int base;
      automatic bit quiet = 1'b1;
      hold_reset();
      en = 4'hF; bsel = 2'b00; pause = 4'd2;
      base = n_log;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (rval || rsx || f_pop != '0) quiet = 1'b0;
      end
      chk(quiet, "R9 idle when none eligible", {31'd0, quiet}, 32'd1);
      push_pkt(2, 0, 2, 2'b10);
      while (!all_done()) @(negedge clk);
      repeat (20) @(negedge clk);
      check_run(base);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk + wd_fail, n_fail + wd_fail);
    $finish;
  end
endmodule